// File: doc/BRIEF.md
# Masked HDLC Address Recognizer

This block sits behind an HDLC receiver that has already found the flags and removed the stuffed zero bits. It looks at the address field at the head of each received frame and decides whether the frame is meant for this station. The address field is the first one or two bytes after the opening flag. It is compared with four programmable 16-bit reference words. Before the comparison, both the received word and each reference word are ANDed with one shared 16-bit mask.

The mask also sets the address length. A mask whose upper byte is zero (for example 0x00FF) gives 8-bit recognition, which uses one byte. Any other mask gives 16-bit recognition, which uses two bytes; the first byte received forms the low half of the compared word. If one reference word holds 0xFFFF under a full mask, the all-ones broadcast address is accepted along with the station's own address.

Each frame produces exactly one decision pulse. The pulse carries accept or discard, and on accept it also carries the number of the matching reference word. The mask and the reference words are sampled when the frame opens, so software may rewrite them at any time without disturbing a frame that is already in progress.

Top module: `hdlc_addr_match`

## Requirements
- R1: The received address word is compared with all four reference words at once, and a match with any one of them accepts the frame.
- R2: A mask bit of 0 makes the matching bit position a don't-care. A mask bit of 1 requires the received bit and the reference bit to be equal.
- R3: When mask bits 15:8 are all zero, recognition is 8-bit. Only the first byte after `rx_sof` is compared, as bits 7:0, and bits 15:8 of every reference word have no effect.
- R4: When mask bits 15:8 are not all zero, recognition is 16-bit. The first byte after `rx_sof` forms bits 7:0 and the second byte forms bits 15:8. The same two bytes in the opposite order do not match a reference word unless that word also matches the swapped value.
- R5: With a mask of 0xFFFF and a reference word of 0xFFFF, the bytes 0xFF, 0xFF are accepted, and a different reference word can still accept its own unicast address in the same setup.
- R6: `dec_valid` is a one-cycle pulse. It is high in the cycle after the cycle that carries the last needed address byte, and it appears exactly once per frame. Bytes after the address field have no effect on it.
- R7: If `rx_eof` arrives before enough address bytes have been received, the frame is discarded. `dec_valid` pulses in the cycle after `rx_eof`, with `dec_accept` at 0 and `dec_index` at 0.
- R8: When more than one reference word matches, `dec_index` reports the lowest-numbered one. On every discard, `dec_index` is 0.
- R9: The mask and the reference words are sampled in the cycle that carries `rx_sof`. A change made while a frame is open takes effect from the next frame onward.
- R10: After reset, and until the first decision, `dec_valid`, `dec_accept` and `dec_index` are all 0. A cycle that carries `rx_sof` carries no data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | Frame opened (opening flag seen); carries no byte |
| rx_valid | input | 1 | `rx_data` holds a received byte |
| rx_data | input | 8 | Received byte, de-stuffed |
| rx_eof | input | 1 | Frame closed; carries no byte |
| cfg_mask | input | 16 | Shared compare mask; upper byte zero selects 8-bit mode |
| cfg_addr | input | 64 | Four reference words; word k sits in bits 16k+15:16k |
| dec_valid | output | 1 | Decision pulse, once per frame |
| dec_accept | output | 1 | 1 = frame accepted, 0 = discarded |
| dec_index | output | 2 | Lowest matching reference word on accept, else 0 |

## Verification
On every cycle, the assertions check that a decision pulse belongs to exactly one frame and lasts one cycle. They also check that `dec_accept` and a nonzero index only appear together with a pulse, that a discard always reports index 0, and that the internal address-complete and early-close events each turn into a pulse one cycle later with the right polarity. Other behaviours can only be shown by the bench's scenarios, each checked against an independently computed expectation. These are: whether the right reference word wins under a given mask, the byte order in 16-bit mode, the broadcast setup, and configuration writes in the middle of a frame.

// File: rtl/hdlc_am_pkg.sv
package hdlc_am_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Equal on every position the mask keeps
  function automatic logic masked_eq(word_t rx_w, word_t ref_w, word_t mask);
    return ((rx_w ^ ref_w) & mask) == '0;
  endfunction

  // Any kept bit in the upper byte means two address bytes
  function automatic logic wide_mode(word_t mask);
    return mask[WORD_W-1:BYTE_W] != '0;
  endfunction
endpackage

// File: rtl/hdlc_am_frame.sv
module hdlc_am_frame
  import hdlc_am_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_sof,
  input  logic                   rx_valid,
  input  byte_t                  rx_data,
  input  logic                   rx_eof,
  input  word_t                  cfg_mask,
  input  logic [NREG*WORD_W-1:0] cfg_addr,
  output logic                   addr_done,
  output logic                   short_end,
  output word_t                  cur_word,
  output word_t                  mask_q,
  output logic [NREG*WORD_W-1:0] addr_q
);
  logic  open_q, decided_q, got_lo_q, wide_q;
  byte_t lo_q;
  logic  take;

  // R9: configuration is sampled only on the frame-open cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      decided_q <= 1'b0;
      got_lo_q  <= 1'b0;
      wide_q    <= 1'b0;
      lo_q      <= '0;
      mask_q    <= '0;
      addr_q    <= '0;
    end else if (rx_sof) begin
      open_q    <= 1'b1;
      decided_q <= 1'b0;
      got_lo_q  <= 1'b0;
      wide_q    <= wide_mode(cfg_mask);
      mask_q    <= cfg_mask;
      addr_q    <= cfg_addr;
    end else if (open_q) begin
      if (take) begin
        if (wide_q && !got_lo_q) begin
          lo_q     <= rx_data;
          got_lo_q <= 1'b1;
        end else begin
          decided_q <= 1'b1;
        end
      end
      if (rx_eof) open_q <= 1'b0;
    end
  end

  assign take      = open_q && !rx_sof && rx_valid && !decided_q;
  assign addr_done = take && (!wide_q || got_lo_q);
  assign short_end = open_q && !rx_sof && rx_eof && !decided_q && !addr_done;
  // R4: the first byte is the low half
  assign cur_word  = wide_q ? {rx_data, lo_q} : {{BYTE_W{1'b0}}, rx_data};
endmodule

// File: rtl/hdlc_am_bank.sv
module hdlc_am_bank
  import hdlc_am_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  word_t                  cur_word,
  input  word_t                  mask_q,
  input  logic [NREG*WORD_W-1:0] addr_q,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       hit_idx
);
  logic [NREG-1:0] hit_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit_vec[g] = masked_eq(cur_word, addr_q[g*WORD_W +: WORD_W], mask_q);
  end

  assign any_hit = |hit_vec;

  // R8: the lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
  import hdlc_am_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_sof,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_eof,
  input  logic [15:0]            cfg_mask,
  input  logic [NREG*16-1:0]     cfg_addr,
  output logic                   dec_valid,
  output logic                   dec_accept,
  output logic [IDX_W-1:0]       dec_index
);
  logic                   addr_done, short_end, any_hit;
  word_t                  cur_word, mask_q;
  logic [NREG*WORD_W-1:0] addr_q;
  logic [IDX_W-1:0]       hit_idx;

  hdlc_am_frame #(.NREG(NREG)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_sof    (rx_sof),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_eof    (rx_eof),
    .cfg_mask  (cfg_mask),
    .cfg_addr  (cfg_addr),
    .addr_done (addr_done),
    .short_end (short_end),
    .cur_word  (cur_word),
    .mask_q    (mask_q),
    .addr_q    (addr_q)
  );

  hdlc_am_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .cur_word (cur_word),
    .mask_q   (mask_q),
    .addr_q   (addr_q),
    .any_hit  (any_hit),
    .hit_idx  (hit_idx)
  );

  // R6, R7: registered decision, one cycle after the deciding event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid  <= addr_done || short_end;
      dec_accept <= addr_done && any_hit;
      dec_index  <= (addr_done && any_hit) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/hdlc_am_checker.sv
module hdlc_am_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sof,
  input logic             addr_done,
  input logic             short_end,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [IDX_W-1:0] dec_index
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (rx_sof)    seen_q <= 1'b0;
    else if (dec_valid) seen_q <= 1'b1;
  end

  p_once_per_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !seen_q);
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !rx_sof |=> !dec_valid);
  p_addr_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> dec_valid);
  p_short_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> dec_valid && !dec_accept && dec_index == '0);
  p_events_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_done, short_end}));
  p_accept_in_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  p_discard_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_accept |-> dec_index == '0);
endmodule

bind hdlc_addr_match hdlc_am_checker #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_sof     (rx_sof),
  .addr_done  (addr_done),
  .short_end  (short_end),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_index  (dec_index)
);

// File: tb/hdlc_addr_match_bench.sv
module hdlc_addr_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [15:0] cfg_mask = 16'h00FF;
  logic [15:0] b_addr [4];
  logic [63:0] cfg_addr;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_index;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int got_cyc = 0;
  logic got_acc = 1'b0;
  logic [1:0] got_idx = '0;
  logic done = 1'b0;

  assign cfg_addr = {b_addr[3], b_addr[2], b_addr[1], b_addr[0]};

  hdlc_addr_match u_hdlc_addr_match (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .cfg_mask(cfg_mask),
    .cfg_addr(cfg_addr), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_index(dec_index)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (dec_valid) begin
    got_cyc = cyc; got_acc = dec_accept; got_idx = dec_index;
    pulses = pulses + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected decision, computed from the requirements
  function automatic int need_of(input logic [15:0] m);
    return (m[15:8] != 8'h00) ? 2 : 1;
  endfunction

  function automatic int ref_idx(input logic [15:0] m, input logic [7:0] b0,
                                 input logic [7:0] b1);
    logic [15:0] w;
    w = (need_of(m) == 2) ? {b1, b0} : {8'h00, b0};
    for (int i = 0; i < 4; i++)
      if (((w & m) == (b_addr[i] & m))) return i;
    return -1;
  endfunction

  logic        pend_en = 1'b0;
  logic [15:0] pend_mask = '0;
  logic [15:0] pend_addr [4];

  task automatic frame(input string req, input int n, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2);
    int need, base, exp_cyc, ei;
    logic [7:0] bk;
    need = need_of(cfg_mask);
    ei = (n >= need) ? ref_idx(cfg_mask, b0, b1) : -1;
    exp_cyc = 0;
    @(negedge clk); rx_sof = 1'b1; base = pulses;
    @(negedge clk); rx_sof = 1'b0;
    if (pend_en) begin
      cfg_mask = pend_mask;
      for (int i = 0; i < 4; i++) b_addr[i] = pend_addr[i];
      pend_en = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      bk = (k == 0) ? b0 : (k == 1) ? b1 : b2;
      rx_valid = 1'b1; rx_data = bk;
      if (k == need - 1) exp_cyc = cyc + 1;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eof = 1'b1;
    if (n < need) exp_cyc = cyc + 1;
    @(negedge clk); rx_eof = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(pulses - base == 1, {req, " R6 pulse count"}, pulses - base, 1);
    chk(got_cyc == exp_cyc, {req, " R6 timing"}, got_cyc, exp_cyc);
    chk(got_acc == (ei >= 0), {req, " accept"}, got_acc, ei >= 0);
    chk(int'(got_idx) == ((ei >= 0) ? ei : 0), {req, " R8 index"}, got_idx,
        (ei >= 0) ? ei : 0);
  endtask

  task automatic set_cfg(input logic [15:0] m, input logic [15:0] a0,
                         input logic [15:0] a1, input logic [15:0] a2,
                         input logic [15:0] a3);
    cfg_mask = m; b_addr[0] = a0; b_addr[1] = a1; b_addr[2] = a2; b_addr[3] = a3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] m;
    int n;
    logic [7:0] x0, x1;
    set_cfg(16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!dec_valid && !dec_accept && dec_index == 0, "R10 reset outputs",
        {dec_valid, dec_accept, dec_index}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dec_valid && !dec_accept && dec_index == 0, "R10 after reset",
        {dec_valid, dec_accept, dec_index}, 0);

    // R3: 8-bit mode, upper register byte ignored
    set_cfg(16'h00FF, 16'h3355, 16'h1111, 16'h2222, 16'h4444);
    frame("R3 8-bit hit", 3, 8'h55, 8'h44, 8'h10);
    frame("R3 8-bit miss", 2, 8'h56, 8'h55, 8'h00);
    // R4: 16-bit mode, byte order
    set_cfg(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hAA68, 16'h0000);
    b_addr[0] = 16'h1234; b_addr[1] = 16'hFFFF;
    frame("R4 16-bit order", 3, 8'h68, 8'hAA, 8'h44);
    frame("R4 swapped miss", 2, 8'hAA, 8'h68, 8'h00);
    // R5: broadcast and unicast together
    frame("R5 broadcast", 2, 8'hFF, 8'hFF, 8'h00);
    frame("R5 unicast", 2, 8'h34, 8'h12, 8'h00);
    // R2: partial mask, R8: priority
    set_cfg(16'h0F0F, 16'h9999, 16'h0505, 16'hF5F5, 16'h0A0A);
    frame("R2 R8 masked priority", 2, 8'h25, 8'h35, 8'h00);
    // R1: only the last register matches
    set_cfg(16'hFFFF, 16'h0001, 16'h0002, 16'h0003, 16'hBEEF);
    frame("R1 last register", 2, 8'hEF, 8'hBE, 8'h00);
    // R7: short frames
    frame("R7 empty frame", 0, 8'h00, 8'h00, 8'h00);
    frame("R7 one byte in 16-bit", 1, 8'h01, 8'h00, 8'h00);
    // R9: write during a frame applies to the next one
    pend_en = 1'b1; pend_mask = 16'h00FF;
    pend_addr[0] = 16'h0077; pend_addr[1] = 16'h0000;
    pend_addr[2] = 16'h0000; pend_addr[3] = 16'h0000;
    set_cfg(16'hFFFF, 16'h0001, 16'h0002, 16'h0003, 16'hBEEF);
    frame("R9 old config holds", 2, 8'h02, 8'h00, 8'h00);
    frame("R9 new config next", 1, 8'h77, 8'h00, 8'h00);

    // Random frames (R1, R2, R3, R4)
    for (int t = 0; t < 400; t++) begin
      case ($urandom_range(0, 2))
        0: m = 16'h00FF;
        1: m = 16'hFFFF;
        default: m = 16'($urandom);
      endcase
      set_cfg(m, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      n = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 1) begin
        int r;
        r = $urandom_range(0, 3);
        x0 = b_addr[r][7:0]; x1 = b_addr[r][15:8];
      end else begin
        x0 = 8'($urandom); x1 = 8'($urandom);
      end
      frame("R1 random", n, x0, x1, 8'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule